// File: doc/BRIEF.md
# Tree-Spread Write Mesh

This block connects a set of processor cores to a set of private memory banks. There is one bank per core, and each bank sits at the same leaf of a binary tree as its core. Every core can issue one write per cycle. A write carries an address, a data word and a spread value. The mesh sends that write to every bank inside the aligned subtree of 2^spread leaves that contains the writing core. Every bank the write reaches gets the same address and the same data.

With spread 0 a write is private to its own core. With the full spread a write is seen by every core. A program can therefore treat each bank as local scratch or as a shared replica, and it chooses per write. The routing from the requests to the bank write ports is purely combinational. When several requests cover the same bank in one cycle, a fixed lowest-index-wins rule picks one of them. Reads never cross the mesh: each core reads only its own bank through a registered read port.

Top module: `tree_wr_mesh`

## Requirements
- R1: Core j's read port returns the contents of bank j only, at the address on core j's read-address field. Core k's fields sit at bit offset k times the field width in every flattened port.
- R2: A write with spread 0 updates only the issuing core's own bank.
- R3: A write from core i with spread s updates bank j exactly when (i >> s) equals (j >> s).
- R4: A spread of log2(N_CORES) or greater reaches all banks. Values above log2(N_CORES) act as log2(N_CORES).
- R5: Every bank a write reaches stores the same data word at the same address.
- R6: When several writes cover one bank in the same cycle, only the write from the lowest-numbered core is performed on that bank. This holds even if the other writes target different addresses. Writes that cover disjoint banks all take effect.
- R7: Read data appears one clock after the read address is presented. A write made on that same edge is not visible in that read; the read returns the old contents.
- R8: A write presented in a cycle is stored at that cycle's clock edge, with no pipeline stage in the mesh. A read addressed in the next cycle returns the new value.
- R9: While rst_ni is low, every read data output is zero.
- R10: When a core's write enable is low, its address, data and spread fields have no effect on any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | N_CORES | Per-core write enable |
| wr_addr_i | input | N_CORES*ADDR_W | Per-core write address |
| wr_data_i | input | N_CORES*DATA_W | Per-core write data |
| wr_spread_i | input | N_CORES*SPREAD_W | Per-core spread value, unsigned |
| rd_addr_i | input | N_CORES*ADDR_W | Per-core read address into its own bank |
| rd_data_o | output | N_CORES*DATA_W | Per-core registered read data |

## Verification
The single-writer sweep runs every core against every spread, including one value far above the saturation point. It tells the exact subtree shape apart from an off-by-one level and from missing saturation. The collision sweep covers every core pair with every spread pair at one shared address. It shows whether the lowest index wins only where the subtrees overlap, and whether disjoint subtrees leave both writes intact. Further directed patterns cover colliding writes to different addresses, a read and a write to the same address on the same edge, and disabled writes that carry live-looking fields. These separate a dropped write from a merged one, old data from forwarded data, and ignored fields from leaking ones.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  // Tree level at which two leaves whose indices differ by xor value diff first share a subtree.
  function automatic int lvl_needed(int diff);
    int n;
    n = 0;
    for (int b = 0; b < 31; b++) begin
      if (((diff >> b) & 1) != 0) n = b + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/tsm_cover.sv
module tsm_cover #(
  parameter int N_CORES  = 4,
  parameter int SPREAD_W = 3
) (
  input  logic [N_CORES-1:0]              wr_en_i,
  input  logic [N_CORES*SPREAD_W-1:0]     spread_i,
  output logic [N_CORES-1:0][N_CORES-1:0] req_o     // [bank][core]
);
  localparam int LVL = $clog2(N_CORES);
  localparam logic [SPREAD_W-1:0] LVL_V = SPREAD_W'(LVL);

  logic [N_CORES-1:0][SPREAD_W-1:0] sat_spread;

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_sat
    logic [SPREAD_W-1:0] raw;
    assign raw            = spread_i[gi*SPREAD_W +: SPREAD_W];
    assign sat_spread[gi] = (raw > LVL_V) ? LVL_V : raw;
  end

  for (genvar gj = 0; gj < N_CORES; gj++) begin : g_bank
    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
      localparam int NEED = tsm_pkg::lvl_needed(gj ^ gi);
      localparam logic [SPREAD_W-1:0] NEED_V = SPREAD_W'(NEED);
      assign req_o[gj][gi] = wr_en_i[gi] && (sat_spread[gi] >= NEED_V);
    end
  end

endmodule

// File: rtl/tsm_arb.sv
module tsm_arb #(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic [N_CORES-1:0]        req_i,
  input  logic [N_CORES*ADDR_W-1:0] addr_i,
  input  logic [N_CORES*DATA_W-1:0] data_i,
  output logic [N_CORES-1:0]        gnt_o,
  output logic                      we_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DATA_W-1:0]         data_o
);
  // lowest set bit wins
  assign gnt_o = req_i & (~req_i + N_CORES'(1));
  assign we_o  = |req_i;

  always_comb begin
    addr_o = '0;
    data_o = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (gnt_o[i]) begin
        addr_o = addr_o | addr_i[i*ADDR_W +: ADDR_W];
        data_o = data_o | data_i[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/tsm_bank.sv
module tsm_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write: old contents on a same-edge collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/tree_wr_mesh.sv
module tree_wr_mesh #(
  parameter int N_CORES  = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int SPREAD_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CORES-1:0]          wr_en_i,
  input  logic [N_CORES*ADDR_W-1:0]   wr_addr_i,
  input  logic [N_CORES*DATA_W-1:0]   wr_data_i,
  input  logic [N_CORES*SPREAD_W-1:0] wr_spread_i,
  input  logic [N_CORES*ADDR_W-1:0]   rd_addr_i,
  output logic [N_CORES*DATA_W-1:0]   rd_data_o
);
  logic [N_CORES-1:0][N_CORES-1:0] cov_req;
  logic [N_CORES-1:0][N_CORES-1:0] gnt;
  logic [N_CORES-1:0]              bank_we;
  logic [N_CORES-1:0][ADDR_W-1:0]  bank_addr;
  logic [N_CORES-1:0][DATA_W-1:0]  bank_data;

  tsm_cover #(
    .N_CORES (N_CORES),
    .SPREAD_W(SPREAD_W)
  ) u_cover (
    .wr_en_i (wr_en_i),
    .spread_i(wr_spread_i),
    .req_o   (cov_req)
  );

  for (genvar gj = 0; gj < N_CORES; gj++) begin : g_bank
    tsm_arb #(
      .N_CORES(N_CORES),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_arb (
      .req_i (cov_req[gj]),
      .addr_i(wr_addr_i),
      .data_i(wr_data_i),
      .gnt_o (gnt[gj]),
      .we_o  (bank_we[gj]),
      .addr_o(bank_addr[gj]),
      .data_o(bank_data[gj])
    );

    tsm_bank #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (bank_we[gj]),
      .waddr_i(bank_addr[gj]),
      .wdata_i(bank_data[gj]),
      .raddr_i(rd_addr_i[gj*ADDR_W +: ADDR_W]),
      .rdata_o(rd_data_o[gj*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/tree_wr_mesh_chk.sv
module tree_wr_mesh_chk #(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_CORES-1:0]              wr_en_i,
  input logic [N_CORES*ADDR_W-1:0]       rd_addr_i,
  input logic [N_CORES*DATA_W-1:0]       rd_data_o,
  input logic [N_CORES-1:0][N_CORES-1:0] cov_req,
  input logic [N_CORES-1:0][N_CORES-1:0] gnt,
  input logic [N_CORES-1:0]              bank_we
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == '0) |-> (bank_we == '0));

  for (genvar gj = 0; gj < N_CORES; gj++) begin : g_b
    p_own_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[gj] |-> cov_req[gj][gj]);
    p_we_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_we[gj] == (|cov_req[gj]));
    p_gnt_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt[gj]));
    p_gnt_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[gj] & ~cov_req[gj]) == '0);
    p_low_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cov_req[gj][0] |-> gnt[gj][0]);
    p_read_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 &&
       $past(rd_addr_i[gj*ADDR_W +: ADDR_W]) == $past(rd_addr_i[gj*ADDR_W +: ADDR_W], 2) &&
       !$past(bank_we[gj], 2))
      |-> $stable(rd_data_o[gj*DATA_W +: DATA_W]));
  end

endmodule

bind tree_wr_mesh tree_wr_mesh_chk #(
  .N_CORES(N_CORES),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .cov_req  (cov_req),
  .gnt      (gnt),
  .bank_we  (bank_we)
);

// File: tb/tree_wr_mesh_test.sv
`timescale 1ns/1ps
module tree_wr_mesh_test;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    wr_en = '0;
  logic [N*AW-1:0] wr_addr = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N*SW-1:0] wr_spread = '0;
  logic [N*AW-1:0] rd_addr = '0;
  logic [N*DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tree_wr_mesh #(.N_CORES(N), .DATA_W(DW), .ADDR_W(AW), .SPREAD_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_spread_i(wr_spread), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  function automatic bit covers(int i, int j, int s);
    return (i >> s) == (j >> s);
  endfunction

  task automatic check(string req, int bank, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bank %0d: actual %02h expected %02h", req, bank, act, exp);
    end
  endtask

  task automatic set_wr(int core, bit en, int addr, int data, int spr);
    wr_en[core]              = en;
    wr_addr[core*AW +: AW]   = AW'(addr);
    wr_data[core*DW +: DW]   = DW'(data);
    wr_spread[core*SW +: SW] = SW'(spr);
  endtask

  task automatic idle_wr();
    wr_en = '0;
  endtask

  // one write cycle with whatever set_wr staged, then release
  task automatic commit();
    @(negedge clk);
    idle_wr();
  endtask

  task automatic clear_addr(int addr);
    set_wr(0, 1'b1, addr, 0, 7);
    commit();
  endtask

  task automatic read_all(int addr);
    for (int j = 0; j < N; j++) rd_addr[j*AW +: AW] = AW'(addr);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] bank_out(int j);
    return rd_data[j*DW +: DW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds read outputs at zero
    repeat (3) @(negedge clk);
    for (int j = 0; j < N; j++) check("R9", j, bank_out(j), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // single writer, every core, every spread including saturating values
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 5; k++) begin
        int s;
        int a;
        int d;
        string tag;
        s = (k == 4) ? 7 : k;
        a = (i * 5 + k) % 16;
        d = 8'h10 * i + k + 1;
        clear_addr(a);
        set_wr(i, 1'b1, a, d, s);
        commit();
        read_all(a);
        tag = (s == 0) ? "R2" : ((s >= 2) ? "R4" : "R3");
        for (int j = 0; j < N; j++)
          check(tag, j, bank_out(j), covers(i, j, s) ? DW'(d) : DW'(0));
      end
    end

    // R6: every pair at a shared address with every spread pair (R5 same word everywhere)
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        for (int sa = 0; sa < 3; sa++) begin
          for (int sb = 0; sb < 3; sb++) begin
            int da;
            int db;
            da = 8'h40 + a * 16 + sa * 4 + sb;
            db = 8'hC0 + b * 16 + sa * 4 + sb;
            clear_addr(3);
            set_wr(a, 1'b1, 3, da, sa);
            set_wr(b, 1'b1, 3, db, sb);
            commit();
            read_all(3);
            for (int j = 0; j < N; j++)
              check("R6", j, bank_out(j),
                    covers(a, j, sa) ? DW'(da) : (covers(b, j, sb) ? DW'(db) : DW'(0)));
          end
        end
      end
    end

    // R6: loser to a different address is dropped entirely
    clear_addr(10);
    clear_addr(11);
    set_wr(0, 1'b1, 10, 8'hA1, 2);
    set_wr(3, 1'b1, 11, 8'hB2, 2);
    commit();
    read_all(10);
    for (int j = 0; j < N; j++) check("R6", j, bank_out(j), 8'hA1);
    read_all(11);
    for (int j = 0; j < N; j++) check("R6", j, bank_out(j), 8'h00);

    // R6/R5: disjoint subtrees both land
    clear_addr(12);
    clear_addr(13);
    set_wr(1, 1'b1, 12, 8'h5C, 1);
    set_wr(2, 1'b1, 13, 8'h6D, 1);
    commit();
    read_all(12);
    for (int j = 0; j < N; j++) check("R6", j, bank_out(j), (j < 2) ? 8'h5C : 8'h00);
    read_all(13);
    for (int j = 0; j < N; j++) check("R6", j, bank_out(j), (j >= 2) ? 8'h6D : 8'h00);

    // R1/R2: private words at one address, read locally
    for (int j = 0; j < N; j++) set_wr(j, 1'b1, 9, 8'h30 + j, 0);
    commit();
    read_all(9);
    for (int j = 0; j < N; j++) check("R1", j, bank_out(j), DW'(8'h30 + j));
    // R1: different read addresses per core
    for (int j = 0; j < N; j++) rd_addr[j*AW +: AW] = (j % 2 == 0) ? AW'(9) : AW'(10);
    @(negedge clk);
    for (int j = 0; j < N; j++)
      check("R1", j, bank_out(j), (j % 2 == 0) ? DW'(8'h30 + j) : DW'(8'hA1));

    // R7/R8: same-edge read and write returns old, next read returns new
    set_wr(0, 1'b1, 5, 8'hAA, 7);
    commit();
    for (int j = 0; j < N; j++) rd_addr[j*AW +: AW] = AW'(5);
    set_wr(0, 1'b1, 5, 8'h55, 7);
    @(negedge clk);
    idle_wr();
    for (int j = 0; j < N; j++) check("R7", j, bank_out(j), 8'hAA);
    @(negedge clk);
    for (int j = 0; j < N; j++) check("R8", j, bank_out(j), 8'h55);

    // R10: disabled write with live fields changes nothing
    for (int j = 0; j < N; j++) set_wr(j, 1'b0, 5, 8'h77, 7);
    @(negedge clk);
    read_all(5);
    for (int j = 0; j < N; j++) check("R10", j, bank_out(j), 8'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule